// File: doc/BRIEF.md
# Eight-bit ALU with packed-decimal arithmetic

This block is the arithmetic and logic unit of a small accumulator processor. It takes an operation code, two 8-bit operands (A, the register-side operand, and M, the memory-side operand), a carry input and a decimal-mode input. From these it produces an 8-bit result, new values for the negative, overflow, zero and carry flags, and one write enable per flag. The surrounding core writes back a flag only when its enable is high, so flags that an operation does not touch keep their values in the status register. Register storage, operand fetch and instruction decode live outside this block.

Add and subtract switch to packed BCD when the decimal input is high. Subtraction is built as A + ~M + carry, so a carry of 1 means no borrow. Compare uses the same adder, with the carry forced to 1 and decimal mode ignored. The result and the flags are registered, and they appear one clock after the inputs. Shifts, rotates, increment and decrement act on operand A. The core routes the accumulator or the memory byte into A.

Top module: `alu8_bcd`

## Requirements
- R1: All outputs are registered. The values for the inputs sampled at a rising clock edge appear right after that edge. A synchronous active-high reset drives the result, every flag and every enable to 0.
- R2: A flag whose enable is low is driven as 0. Wherever Z comes from the result, N equals result bit 7 and Z is 1 only when the result is 0x00.
- R3: ADD (op 0) with decimal low gives A + M + C. C is the carry out of bit 7. V is 1 when A and M have the same sign and the result sign differs. All four enables are high.
- R4: SUB (op 1) with decimal low gives A + ~M + C. C is the carry out, so 1 means no borrow. V follows the R3 rule applied to A and ~M. All four enables are high.
- R5: With decimal high and valid BCD operands, ADD gives the packed-BCD sum (0x09 + 0x01 = 0x10, and 0x99 + 0x01 = 0x00 with C=1). SUB gives the packed-BCD difference, minus 1 when C is 0, with C=0 on a borrow. N and Z come from the decimal result and V from the binary sum.
- R6: AND (op 2), OR (op 3) and XOR (op 4) combine A with M and enable only N and Z.
- R7: ASL (op 5) shifts A left, fills with 0 and puts A bit 7 in C. LSR (op 6) shifts A right, fills with 0, puts A bit 0 in C and forces N to 0. Both enable N, Z and C.
- R8: ROL (op 7) shifts A left with C entering bit 0 and bit 7 leaving to C. ROR (op 8) shifts A right with C entering bit 7 and bit 0 leaving to C. Both enable N, Z and C.
- R9: CMP (op 9) returns A unchanged as the result. N and Z come from the 8-bit A - M, and C is 1 when A >= M unsigned. This holds even when decimal is high. V is not enabled.
- R10: BIT (op 10, memory form) returns A, sets Z when A AND M is 0, copies M bit 7 to N and M bit 6 to V, and enables only N, V and Z. BIT immediate (op 11) returns A and enables only Z, with the same Z.
- R11: TSB (op 12) returns A OR M and TRB (op 13) returns ~A AND M. Both set Z from A AND M and enable only Z.
- R12: INC (op 14) returns A + 1 and DEC (op 15) returns A - 1, both modulo 256, and enable only N and Z.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Operation code |
| a_i | input | 8 | Register-side operand |
| m_i | input | 8 | Memory-side operand |
| c_i | input | 1 | Carry flag in |
| d_i | input | 1 | Decimal-mode flag |
| res_o | output | 8 | Result |
| n_o | output | 1 | Next negative flag |
| v_o | output | 1 | Next overflow flag |
| z_o | output | 1 | Next zero flag |
| c_o | output | 1 | Next carry flag |
| wn_o | output | 1 | Negative flag write enable |
| wv_o | output | 1 | Overflow flag write enable |
| wz_o | output | 1 | Zero flag write enable |
| wc_o | output | 1 | Carry flag write enable |

## Verification
The assertions assume that the inputs are driven to known values from the first clock on and stay stable around each rising edge. The stimulus keeps to this by holding the inputs at defined values during reset and changing them only on falling edges. Decimal results are defined only for operands whose nibbles are all 0 to 9. For that reason every vector sent to ADD or SUB with decimal high uses operands built from decimal digits. Decimal-high vectors for all other operations may use any operand values, since those operations must ignore the mode.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_XOR  = 4'd4,
    OP_ASL  = 4'd5,
    OP_LSR  = 4'd6,
    OP_ROL  = 4'd7,
    OP_ROR  = 4'd8,
    OP_CMP  = 4'd9,
    OP_BIT  = 4'd10,
    OP_BITI = 4'd11,
    OP_TSB  = 4'd12,
    OP_TRB  = 4'd13,
    OP_INC  = 4'd14,
    OP_DEC  = 4'd15
  } op_e;

  typedef struct packed {
    logic n;
    logic v;
    logic z;
    logic c;
  } flags_t;
endpackage

// File: rtl/alu_bcd_adj.sv
module alu_bcd_adj #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] mx,
  input  logic         cin,
  input  logic         sub,
  output logic [W-1:0] res,
  output logic         cout
);
  localparam int NDIG = W / 4;

  logic [NDIG:0] dc;
  assign dc[0] = cin;

  for (genvar g = 0; g < NDIG; g++) begin : g_dig
    logic [4:0] t;
    logic       gt9;
    assign t   = {1'b0, a[g*4 +: 4]} + {1'b0, mx[g*4 +: 4]} + {4'd0, dc[g]};
    assign gt9 = (t > 5'd9);
    always_comb begin
      if (sub) begin
        dc[g+1]       = t[4];
        res[g*4 +: 4] = t[4] ? t[3:0] : t[3:0] + 4'd10;
      end else begin
        dc[g+1]       = gt9;
        res[g*4 +: 4] = gt9 ? t[3:0] + 4'd6 : t[3:0];
      end
    end
  end

  assign cout = dc[NDIG];
endmodule

// File: rtl/alu_adder.sv
module alu_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] m,
  input  logic         cin,
  input  logic         sub,
  output logic [W-1:0] bsum,
  output logic         bcout,
  output logic         bv,
  output logic [W-1:0] dsum,
  output logic         dcout
);
  logic [W-1:0] mx;
  logic [W:0]   wide;

  assign mx    = sub ? ~m : m;
  assign wide  = {1'b0, a} + {1'b0, mx} + {{W{1'b0}}, cin};
  assign bsum  = wide[W-1:0];
  assign bcout = wide[W];
  assign bv    = (a[W-1] == mx[W-1]) && (bsum[W-1] != a[W-1]);

  alu_bcd_adj #(.W(W)) u_bcd (
    .a    (a),
    .mx   (mx),
    .cin  (cin),
    .sub  (sub),
    .res  (dsum),
    .cout (dcout)
  );
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int W = 8
) (
  input  alu8_pkg::op_e op,
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  m,
  input  logic          cin,
  output logic [W-1:0]  res,
  output logic          cout
);
  import alu8_pkg::*;

  always_comb begin
    res  = a;
    cout = 1'b0;
    case (op)
      OP_AND:  res = a & m;
      OP_OR:   res = a | m;
      OP_XOR:  res = a ^ m;
      OP_ASL:  begin res = {a[W-2:0], 1'b0}; cout = a[W-1]; end
      OP_LSR:  begin res = {1'b0, a[W-1:1]}; cout = a[0];   end
      OP_ROL:  begin res = {a[W-2:0], cin};  cout = a[W-1]; end
      OP_ROR:  begin res = {cin, a[W-1:1]};  cout = a[0];   end
      OP_TSB:  res = a | m;
      OP_TRB:  res = ~a & m;
      OP_INC:  res = a + {{(W-1){1'b0}}, 1'b1};
      OP_DEC:  res = a - {{(W-1){1'b0}}, 1'b1};
      default: res = a;
    endcase
  end
endmodule

// File: rtl/alu8_bcd.sv
module alu8_bcd #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [3:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] m_i,
  input  logic         c_i,
  input  logic         d_i,
  output logic [W-1:0] res_o,
  output logic         n_o,
  output logic         v_o,
  output logic         z_o,
  output logic         c_o,
  output logic         wn_o,
  output logic         wv_o,
  output logic         wz_o,
  output logic         wc_o
);
  import alu8_pkg::*;

  op_e          op;
  logic         add_sub, add_cin;
  logic [W-1:0] bsum, dsum, lres, res_nxt, res_q;
  logic         bcout, bv, dcout, lcout, andz;
  flags_t       fl_nxt, we_nxt, fl_q, we_q;

  assign op      = op_e'(op_i);
  assign add_sub = (op != OP_ADD);
  assign add_cin = (op == OP_CMP) ? 1'b1 : c_i;
  assign andz    = ((a_i & m_i) == '0);

  alu_adder #(.W(W)) u_add (
    .a     (a_i),
    .m     (m_i),
    .cin   (add_cin),
    .sub   (add_sub),
    .bsum  (bsum),
    .bcout (bcout),
    .bv    (bv),
    .dsum  (dsum),
    .dcout (dcout)
  );

  alu_logic #(.W(W)) u_logic (
    .op   (op),
    .a    (a_i),
    .m    (m_i),
    .cin  (c_i),
    .res  (lres),
    .cout (lcout)
  );

  always_comb begin
    res_nxt = a_i;
    fl_nxt  = '0;
    we_nxt  = '0;
    case (op)
      OP_ADD, OP_SUB: begin
        res_nxt  = d_i ? dsum : bsum;
        fl_nxt.n = res_nxt[W-1];
        fl_nxt.z = (res_nxt == '0);
        fl_nxt.c = d_i ? dcout : bcout;
        fl_nxt.v = bv;
        we_nxt   = 4'b1111;
      end
      OP_AND, OP_OR, OP_XOR, OP_INC, OP_DEC: begin
        res_nxt  = lres;
        fl_nxt.n = lres[W-1];
        fl_nxt.z = (lres == '0);
        we_nxt   = 4'b1010;
      end
      OP_ASL, OP_LSR, OP_ROL, OP_ROR: begin
        res_nxt  = lres;
        fl_nxt.n = lres[W-1];
        fl_nxt.z = (lres == '0);
        fl_nxt.c = lcout;
        we_nxt   = 4'b1011;
      end
      OP_CMP: begin
        res_nxt  = a_i;
        fl_nxt.n = bsum[W-1];
        fl_nxt.z = (bsum == '0);
        fl_nxt.c = bcout;
        we_nxt   = 4'b1011;
      end
      OP_BIT: begin
        fl_nxt.n = m_i[W-1];
        fl_nxt.v = m_i[W-2];
        fl_nxt.z = andz;
        we_nxt   = 4'b1110;
      end
      OP_BITI: begin
        fl_nxt.z = andz;
        we_nxt   = 4'b0010;
      end
      OP_TSB, OP_TRB: begin
        res_nxt  = lres;
        fl_nxt.z = andz;
        we_nxt   = 4'b0010;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q <= '0;
      fl_q  <= '0;
      we_q  <= '0;
    end else begin
      res_q <= res_nxt;
      fl_q  <= fl_nxt;
      we_q  <= we_nxt;
    end
  end

  assign res_o = res_q;
  assign n_o   = fl_q.n;
  assign v_o   = fl_q.v;
  assign z_o   = fl_q.z;
  assign c_o   = fl_q.c;
  assign wn_o  = we_q.n;
  assign wv_o  = we_q.v;
  assign wz_o  = we_q.z;
  assign wc_o  = we_q.c;

  // R2
  disabled_flag_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ((fl_q & ~we_q) == 4'b0000));

  // R7
  lsr_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_LSR) |-> (!fl_nxt.n && fl_nxt.c == a_i[0] && lres[W-1] == 1'b0));

  // R7
  asl_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_ASL) |-> (lcout == a_i[W-1] && lres[0] == 1'b0));

  // R9
  cmp_keeps_a_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_CMP) |=> (res_o == $past(a_i) && !wv_o));

  // R12
  incdec_nz_only_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_INC || op == OP_DEC) |=> (!wv_o && !wc_o && wn_o && wz_o));

  // R5
  bcd_digit_chk: assert property (@(posedge clk) disable iff (rst)
    (d_i && !add_sub && a_i[3:0] <= 4'd9 && m_i[3:0] <= 4'd9) |-> (dsum[3:0] <= 4'd9));
endmodule

// File: tb/alu8_bcd_test.sv
module alu8_bcd_test;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    string      tag;
    logic [7:0] res;
    logic [3:0] fl;
    logic [3:0] we;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] op_i = 4'd0;
  logic [7:0] a_i = 8'd0, m_i = 8'd0;
  logic       c_i = 1'b0, d_i = 1'b0;
  logic [7:0] res_o;
  logic       n_o, v_o, z_o, c_o, wn_o, wv_o, wz_o, wc_o;

  int   checks = 0, errors = 0;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  alu8_bcd uut (
    .clk(clk), .rst(rst), .op_i(op_i), .a_i(a_i), .m_i(m_i), .c_i(c_i), .d_i(d_i),
    .res_o(res_o), .n_o(n_o), .v_o(v_o), .z_o(z_o), .c_o(c_o),
    .wn_o(wn_o), .wv_o(wv_o), .wz_o(wz_o), .wc_o(wc_o)
  );

  function automatic string tag_of(input logic [3:0] op, input logic d);
    case (op)
      4'd0, 4'd1:   return d ? "R5" : (op == 4'd0 ? "R3" : "R4");
      4'd2, 4'd3, 4'd4: return "R6";
      4'd5, 4'd6:   return "R7";
      4'd7, 4'd8:   return "R8";
      4'd9:         return "R9";
      4'd10, 4'd11: return "R10";
      4'd12, 4'd13: return "R11";
      default:      return "R12";
    endcase
  endfunction

  function automatic int bcd2i(input logic [7:0] b);
    return 10 * int'(b[7:4]) + int'(b[3:0]);
  endfunction

  function automatic logic [7:0] i2bcd(input int v);
    logic [7:0] r;
    r[7:4] = 4'((v / 10) % 10);
    r[3:0] = 4'(v % 10);
    return r;
  endfunction

  function automatic exp_t model(input logic [3:0] op, input logic [7:0] a, input logic [7:0] m,
                                 input logic c, input logic d);
    exp_t e;
    logic [8:0] s;
    logic [7:0] mx, r;
    logic n, v, z, cy;
    int t;
    r = a; n = 0; v = 0; z = 0; cy = 0;
    e.we = 4'b0000;
    case (op)
      4'd0, 4'd1: begin
        mx = (op == 4'd1) ? ~m : m;
        s  = {1'b0, a} + {1'b0, mx} + {8'd0, c};
        v  = (a[7] == mx[7]) && (s[7] != a[7]);
        if (!d) begin r = s[7:0]; cy = s[8]; end
        else if (op == 4'd0) begin
          t = bcd2i(a) + bcd2i(m) + int'(c);
          cy = (t >= 100); r = i2bcd(t % 100);
        end else begin
          t = bcd2i(a) - bcd2i(m) - (c ? 0 : 1);
          cy = (t >= 0); r = i2bcd(t < 0 ? t + 100 : t);
        end
        n = r[7]; z = (r == 0); e.we = 4'b1111;
      end
      4'd2, 4'd3, 4'd4, 4'd14, 4'd15: begin
        case (op)
          4'd2: r = a & m;
          4'd3: r = a | m;
          4'd4: r = a ^ m;
          4'd14: r = a + 8'd1;
          default: r = a - 8'd1;
        endcase
        n = r[7]; z = (r == 0); e.we = 4'b1010;
      end
      4'd5, 4'd6, 4'd7, 4'd8: begin
        case (op)
          4'd5: begin r = {a[6:0], 1'b0}; cy = a[7]; end
          4'd6: begin r = {1'b0, a[7:1]}; cy = a[0]; end
          4'd7: begin r = {a[6:0], c};    cy = a[7]; end
          default: begin r = {c, a[7:1]}; cy = a[0]; end
        endcase
        n = r[7]; z = (r == 0); e.we = 4'b1011;
      end
      4'd9: begin
        r = a; t = int'(a) - int'(m);
        n = 1'(t >>> 7); z = (a == m); cy = (a >= m); e.we = 4'b1011;
        n = logic'((a - m) >> 7);
      end
      4'd10: begin n = m[7]; v = m[6]; z = ((a & m) == 0); e.we = 4'b1110; end
      4'd11: begin z = ((a & m) == 0); e.we = 4'b0010; end
      default: begin
        r = (op == 4'd12) ? (a | m) : (~a & m);
        z = ((a & m) == 0); e.we = 4'b0010;
      end
    endcase
    e.res = r;
    e.fl  = {n, v, z, cy};
    e.tag = tag_of(op, d);
    return e;
  endfunction

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic drive(input logic [3:0] op, input logic [7:0] a, input logic [7:0] m,
                       input logic c, input logic d);
    @(negedge clk);
    op_i = op; a_i = a; m_i = m; c_i = c; d_i = d;
    sb.push_back(model(op, a, m, c, d));
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        e = sb.pop_front();
        check(e.tag, {res_o, n_o, v_o, z_o, c_o, wn_o, wv_o, wz_o, wc_o},
                     {e.res, e.fl, e.we});
      end
    end
  end

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    logic [7:0] ra, rm;
    logic [3:0] rop;
    logic rc, rd;
    op_i = 4'd0; a_i = 8'h55; m_i = 8'hAA; c_i = 1'b1; d_i = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    // R1 reset state
    check("R1", {res_o, n_o, v_o, z_o, c_o, wn_o, wv_o, wz_o, wc_o}, 16'h0000);
    @(negedge clk);
    rst = 1'b0;
    // R3 binary add, overflow, carry
    drive(4'd0, 8'h09, 8'h01, 0, 0);
    drive(4'd0, 8'h7F, 8'h01, 0, 0);
    drive(4'd0, 8'hFF, 8'h01, 0, 0);
    drive(4'd0, 8'h10, 8'h20, 1, 0);
    // R4 binary subtract
    drive(4'd1, 8'h50, 8'h30, 1, 0);
    drive(4'd1, 8'h00, 8'h01, 1, 0);
    drive(4'd1, 8'h80, 8'h01, 1, 0);
    drive(4'd1, 8'h05, 8'h05, 0, 0);
    // R5 decimal add and subtract
    drive(4'd0, 8'h09, 8'h01, 0, 1);
    drive(4'd0, 8'h99, 8'h01, 0, 1);
    drive(4'd0, 8'h45, 8'h55, 1, 1);
    drive(4'd1, 8'h10, 8'h01, 1, 1);
    drive(4'd1, 8'h00, 8'h01, 1, 1);
    drive(4'd1, 8'h42, 8'h42, 0, 1);
    // R6 logic
    drive(4'd2, 8'hF0, 8'h3C, 0, 0);
    drive(4'd3, 8'h00, 8'h00, 1, 1);
    drive(4'd4, 8'hA5, 8'h5A, 0, 0);
    // R7 shifts
    drive(4'd5, 8'h81, 8'h00, 0, 0);
    drive(4'd6, 8'h01, 8'h00, 1, 0);
    drive(4'd6, 8'hFE, 8'h00, 0, 1);
    // R8 rotates
    drive(4'd7, 8'h80, 8'h00, 1, 0);
    drive(4'd8, 8'h01, 8'h00, 1, 0);
    drive(4'd8, 8'h01, 8'h00, 0, 0);
    // R9 compare, decimal must not matter
    drive(4'd9, 8'h42, 8'h42, 0, 1);
    drive(4'd9, 8'h10, 8'h20, 0, 1);
    drive(4'd9, 8'h20, 8'h10, 0, 0);
    // R10 bit test, memory and immediate
    drive(4'd10, 8'h0F, 8'hC0, 0, 0);
    drive(4'd10, 8'hFF, 8'h41, 0, 0);
    drive(4'd11, 8'h0F, 8'hC0, 0, 0);
    // R11 test and set / reset
    drive(4'd12, 8'h0F, 8'hF0, 0, 0);
    drive(4'd13, 8'h0F, 8'hFF, 0, 0);
    // R12 increment and decrement wrap
    drive(4'd14, 8'hFF, 8'h00, 1, 0);
    drive(4'd15, 8'h00, 8'h00, 1, 1);
    drive(4'd14, 8'h7F, 8'h00, 0, 0);
    // R2 mixed vectors across all operations
    for (int i = 0; i < 400; i++) begin
      rop = 4'($urandom_range(0, 15));
      ra  = 8'($urandom);
      rm  = 8'($urandom);
      rc  = 1'($urandom);
      rd  = 1'($urandom);
      if (rd && rop <= 4'd1) begin
        ra = i2bcd($urandom_range(0, 99));
        rm = i2bcd($urandom_range(0, 99));
      end
      drive(rop, ra, rm, rc, rd);
    end
    // R1 reset clears after activity
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R1", {res_o, n_o, v_o, z_o, c_o, wn_o, wv_o, wz_o, wc_o}, 16'h0000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule